// File: doc/BRIEF.md
# Serial Port with Transmit and Receive Queues

This block is an asynchronous serial port controlled through a small word-indexed register bus. Software pushes characters into a transmit queue. The transmitter takes them one at a time and shifts them out on the serial output line. It adds a start bit, optional parity and one or two stop bits. The receiver watches the serial input line for a start edge and rebuilds each character. It stores the character in a receive queue and latches any parity or framing fault.

A single control word sets the bit rate, the frame format, the enables, the line polarities and the interrupt enables. Three self-clearing command bits in the same word reset the queues and clear the error flags. A status word reports the queue fill levels, the flags and the engine activity. The register bus has no back-pressure. A write or a read completes in the cycle it is presented. A character written to a full transmit queue is dropped and flagged. A read of an empty receive queue returns zero and changes nothing.

Register index map on `bus_addr`:
- 0: transmit queue write
- 1: receive queue read
- 2: control
- 3: status
- 4: reserved, reads zero

Software byte offsets are these indices times four.

Top module: `ser_unit`

## Requirements
- R1: The control register reads back what was written, except bits 22, 23 and 24, which always read 0. Index 4 and index 0 read as zero.
- R2: Control bits [11:0] hold a divisor D. Every serial bit lasts 4·(D+1) clock cycles.
- R3: Characters are sent and received LSB first, after a low start bit. Control bits [21:20] set the length: 0 gives 8 data bits, 1 gives 7, 2 gives 6 and 3 gives 5. A received character is zero-extended.
- R4: Control bit 19 enables a parity bit after the data, and bit 18 selects odd (1) or even (0) parity. A received parity mismatch sets status bit 16, and the character is still queued.
- R5: Control bits [17:16] equal to 1 send two stop bits, and 0 sends one. A received stop bit sampled low sets status bit 17, and the character is still queued.
- R6: Status [6:0] is the receive count and [14:8] is the transmit count. The flags are bit 19 receive full, bit 20 receive empty, bit 21 transmit full and bit 22 transmit empty. Each queue holds 64 characters. Reading an empty receive queue returns 0.
- R7: A write to a full transmit queue is dropped and sets status bit 18.
- R8: Writing 1 to control bit 22 empties the transmit queue and stops the transmitter. Bit 23 empties the receive queue and stops the receiver. Bit 24 clears status bits 16 to 18.
- R9: Control bit 26 inverts the serial output and bit 25 inverts the serial input, each on its own.
- R10: Control bit 12 enables the transmitter and bit 13 the receiver. While the transmitter is disabled, queued characters stay queued and the output holds the idle level.
- R11: Unless control bit 15 is set, a character starts only while `cts_in` XOR control bit 29 is 1. `rts_out` is (receive queue not full) XOR control bit 31.
- R12: `irq_rx` is control bit 27 AND (receive queue not empty OR (control bit 30 clear AND status bit 16 or 17 set)). `irq_tx` is control bit 28 AND transmit queue empty.
- R13: Status bit 25 is 1 while a character is being sent. Status bit 26 is 1 while one is being received.
- R14: After reset, the control word is 0, the status word is 0x0050_0000, the serial output is high and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops the receive queue at index 1 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ser_txd | output | 1 | Serial output line |
| ser_rxd | input | 1 | Serial input line, asynchronous |
| cts_in | input | 1 | Clear-to-send input |
| rts_out | output | 1 | Ready-to-receive output |
| irq_rx | output | 1 | Receive interrupt, level |
| irq_tx | output | 1 | Transmit interrupt, level |

## Verification
A corrupted queue pointer or count shows in the status word on the very next read, and the data returned by the next pop is wrong. A bit counter or prescaler that drifts stretches or shortens a serial bit. With the port looped back, this becomes a wrong character or a latched parity or framing flag within one frame time, about 4·(D+1)·12 cycles. A broken one-shot or a stale flag shows on the following status read, or at once on the interrupt pins.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // register indices seen by software
  localparam logic [2:0] REG_TXQ  = 3'd0;
  localparam logic [2:0] REG_RXQ  = 3'd1;
  localparam logic [2:0] REG_CTRL = 3'd2;
  localparam logic [2:0] REG_STAT = 3'd3;

  localparam int DIV_W = 12;

  // control word, MSB first; positions are software-visible
  typedef struct packed {
    logic             inv_rts;
    logic             mask_err;
    logic             inv_cts;
    logic             tint_en;
    logic             rint_en;
    logic             inv_tx;
    logic             inv_rx;
    logic             clr_err;
    logic             rst_rx;
    logic             rst_tx;
    logic [1:0]       char_len;
    logic             par_en;
    logic             par_odd;
    logic [1:0]       stop_sel;
    logic             two_wire;
    logic             spare;
    logic             rx_en;
    logic             tx_en;
    logic [DIV_W-1:0] divisor;
  } ctrl_t;

  localparam logic [31:0] ONESHOT_MASK = 32'h01C0_0000;
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (clr) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic             cts_ok,
  input  logic [DIV_W-1:0] divisor,
  input  logic [3:0]       nbits,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  input  logic             q_empty,
  input  logic [7:0]       q_data,
  output logic             pop,
  output logic             line,
  output logic             busy
);
  logic             busy_q;
  logic [11:0]      sh_q, frame;
  logic [3:0]       left_q, total;
  logic [DIV_W-1:0] pre_q;
  logic [1:0]       qtr_q;
  logic             tick, bit_end, par_bit;
  logic [7:0]       dmask;

  assign dmask   = 8'hFF >> (4'd8 - nbits);
  assign par_bit = (^(q_data & dmask)) ^ par_odd;
  assign total   = 4'd2 + nbits + {3'd0, par_en} + {3'd0, two_stop};

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nbits)) frame[i+1] = q_data[i];
    for (int i = 0; i < 12; i++)
      if (par_en && i == int'(nbits) + 1) frame[i] = par_bit;
  end

  assign pop     = !busy_q && enable && cts_ok && !q_empty && !clr;
  assign tick    = busy_q && (pre_q == divisor);
  assign bit_end = tick && (qtr_q == 2'd3);
  assign line    = busy_q ? sh_q[0] : 1'b1;
  assign busy    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sh_q <= '1; left_q <= '0; pre_q <= '0; qtr_q <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
    end else if (pop) begin
      busy_q <= 1'b1; sh_q <= frame; left_q <= total;
      pre_q  <= '0;   qtr_q <= '0;
    end else if (busy_q) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) qtr_q <= qtr_q + 1'b1;
      if (bit_end) begin
        sh_q   <= {1'b1, sh_q[11:1]};
        left_q <= left_q - 1'b1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end
    end
  end

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_end && !clr) |=> $stable(line));
endmodule

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic             line,
  input  logic [DIV_W-1:0] divisor,
  input  logic [3:0]       nbits,
  input  logic             par_en,
  input  logic             par_odd,
  output logic             push,
  output logic [7:0]       data,
  output logic             par_bad,
  output logic             frame_bad,
  output logic             busy
);
  logic             busy_q, prev_q, pbad_q;
  logic [DIV_W-1:0] pre_q;
  logic [1:0]       qtr_q;
  logic [3:0]       idx_q, par_idx, stop_idx;
  logic [7:0]       sh_q;
  logic             tick, samp;

  assign tick      = busy_q && (pre_q == divisor);
  assign samp      = tick && (qtr_q == 2'd1);
  assign par_idx   = nbits + 4'd1;
  assign stop_idx  = nbits + 4'd1 + {3'd0, par_en};
  assign data      = sh_q >> (4'd8 - nbits);
  assign push      = samp && (idx_q == stop_idx) && !clr;
  assign frame_bad = push && !line;
  assign par_bad   = push && pbad_q;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; prev_q <= 1'b1; pbad_q <= 1'b0;
      pre_q  <= '0;   qtr_q  <= '0;   idx_q  <= '0; sh_q <= '0;
    end else begin
      prev_q <= line;
      if (clr) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        if (enable && prev_q && !line) begin
          busy_q <= 1'b1; pre_q <= '0; qtr_q <= '0;
          idx_q  <= '0;   pbad_q <= 1'b0;
        end
      end else begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) qtr_q <= qtr_q + 1'b1;
        if (samp) begin
          if (idx_q == 4'd0) begin
            if (line) busy_q <= 1'b0;
            else      idx_q  <= 4'd1;
          end else if (idx_q <= nbits) begin
            sh_q  <= {line, sh_q[7:1]};
            idx_q <= idx_q + 1'b1;
          end else if (par_en && idx_q == par_idx) begin
            pbad_q <= ((^data) ^ line) != par_odd;
            idx_q  <= idx_q + 1'b1;
          end else begin
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  // R5
  rx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !busy_q);
endmodule

// File: rtl/ser_unit.sv
module ser_unit
  import ser_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        ser_txd,
  input  logic        ser_rxd,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        irq_rx,
  output logic        irq_tx
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  ctrl_t          ctrl_q, wctl;
  logic           wr_txq, wr_ctrl, rd_rxq;
  logic           rst_tx_p, rst_rx_p, clr_err_p;
  logic           perr_q, ferr_q, wferr_q;
  logic [1:0]     rx_sync_q;
  logic           line_in, tx_line, cts_ok, two_stop;
  logic [3:0]     nbits;
  logic [31:0]    status;

  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]     tx_dout, rx_dout, rx_data;
  logic           tx_pop, tx_busy, rx_push, rx_pbad, rx_fbad, rx_busy;

  assign wctl      = ctrl_t'(bus_wdata);
  assign wr_txq    = bus_wr && (bus_addr == REG_TXQ);
  assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
  assign rd_rxq    = bus_rd && (bus_addr == REG_RXQ);
  assign rst_tx_p  = wr_ctrl && wctl.rst_tx;
  assign rst_rx_p  = wr_ctrl && wctl.rst_rx;
  assign clr_err_p = wr_ctrl && wctl.clr_err;

  assign nbits    = 4'd8 - {2'd0, ctrl_q.char_len};
  assign two_stop = (ctrl_q.stop_sel == 2'd1);
  assign cts_ok   = ctrl_q.two_wire || (cts_in ^ ctrl_q.inv_cts);
  assign line_in  = rx_sync_q[1] ^ ctrl_q.inv_rx;
  assign ser_txd  = tx_line ^ ctrl_q.inv_tx;
  assign rts_out  = !rx_full ^ ctrl_q.inv_rts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rx_sync_q <= 2'b11;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      wferr_q   <= 1'b0;
    end else begin
      rx_sync_q <= {rx_sync_q[0], ser_rxd};
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata & ~ONESHOT_MASK);
      if (clr_err_p) begin
        perr_q <= 1'b0; ferr_q <= 1'b0; wferr_q <= 1'b0;
      end
      if (rx_pbad)           perr_q  <= 1'b1;
      if (rx_fbad)           ferr_q  <= 1'b1;
      if (wr_txq && tx_full) wferr_q <= 1'b1;
    end
  end

  ser_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(rst_tx_p), .push(wr_txq),
    .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty));

  ser_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rst_rx_p), .push(rx_push),
    .din(rx_data), .pop(rd_rxq), .dout(rx_dout), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty));

  ser_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(rst_tx_p), .enable(ctrl_q.tx_en),
    .cts_ok(cts_ok), .divisor(ctrl_q.divisor), .nbits(nbits),
    .par_en(ctrl_q.par_en), .par_odd(ctrl_q.par_odd), .two_stop(two_stop),
    .q_empty(tx_empty), .q_data(tx_dout), .pop(tx_pop), .line(tx_line),
    .busy(tx_busy));

  ser_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rst_rx_p), .enable(ctrl_q.rx_en),
    .line(line_in), .divisor(ctrl_q.divisor), .nbits(nbits),
    .par_en(ctrl_q.par_en), .par_odd(ctrl_q.par_odd), .push(rx_push),
    .data(rx_data), .par_bad(rx_pbad), .frame_bad(rx_fbad), .busy(rx_busy));

  assign status = {5'd0, rx_busy, tx_busy, 2'd0,
                   tx_empty, tx_full, rx_empty, rx_full,
                   wferr_q, ferr_q, perr_q,
                   1'b0, 7'(tx_cnt), 1'b0, 7'(rx_cnt)};

  always_comb begin
    case (bus_addr)
      REG_RXQ:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
      REG_CTRL: bus_rdata = ctrl_q;
      REG_STAT: bus_rdata = status;
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign irq_rx = ctrl_q.rint_en &&
                  (!rx_empty || (!ctrl_q.mask_err && (perr_q || ferr_q)));
  assign irq_tx = ctrl_q.tint_en && tx_empty;

  // R7
  wfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txq && tx_full) |=> wferr_q);

  // R8
  txrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_tx_p |=> (tx_cnt == '0) && !tx_busy);

  // R8
  rxrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rx_p |=> (rx_cnt == '0) && !rx_busy);

  // R11
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.two_wire && !(cts_in ^ ctrl_q.inv_cts) && !tx_busy) |=> !tx_busy);
endmodule

// File: tb/sim_ser_unit.sv
module sim_ser_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ser_txd, ser_rxd, cts_in = 1'b1, rts_out, irq_rx, irq_tx;
  logic        loop = 1'b1, rxd_drv = 1'b1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ser_rxd = loop ? ser_txd : rxd_drv;

  ser_unit u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ser_txd(ser_txd), .ser_rxd(ser_rxd), .cts_in(cts_in), .rts_out(rts_out),
    .irq_rx(irq_rx), .irq_tx(irq_tx));

  // vector: [20:19] len code, [18] parity on, [17] odd, [16] two stop,
  //         [15:8] char written, [7:0] char expected back
  localparam logic [20:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {2'd1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h7F},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h3C},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h1A},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00},
    {2'd0, 1'b1, 1'b0, 1'b1, 8'h81, 8'h81}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive n bits LSB first, 8 clocks each (divisor 1)
  task automatic drive(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd_drv = bits[i];
      repeat (7) @(negedge clk);
    end
    @(negedge clk); rxd_drv = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cfg;
    int          w;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R14 reset state
    rd(3'd3, d); chk("R14 status", d, 32'h0050_0000);
    rd(3'd2, d); chk("R14 ctrl", d, 32'h0);
    chk("R14 txd", {31'd0, ser_txd}, 32'd1);
    chk("R14 irqs", {30'd0, irq_rx, irq_tx}, 32'd0);
    chk("R11 rts idle", {31'd0, rts_out}, 32'd1);

    // R1 readback, one-shots read 0, misc and tx index read 0
    wr(3'd2, 32'hA1C0_0ABC);
    rd(3'd2, d); chk("R1 ctrl readback", d, 32'hA000_0ABC);
    rd(3'd4, d); chk("R1 misc zero", d, 32'h0);
    rd(3'd0, d); chk("R1 txq reads zero", d, 32'h0);
    wr(3'd2, 32'h0);

    // R6 empty receive read returns 0
    rd(3'd1, d); chk("R6 empty read", d, 32'h0);

    // R10 R7 fill transmitter while disabled, one extra write
    for (int i = 0; i < 65; i++) wr(3'd0, 32'(i));
    rd(3'd3, d); chk("R7 R10 full status", d, 32'h0034_4000);
    chk("R10 txd idle", {31'd0, ser_txd}, 32'd1);

    // R8 clear errors, then reset transmit queue
    wr(3'd2, 32'h0100_0000);
    rd(3'd3, d); chk("R8 clear err", d, 32'h0030_4000);
    wr(3'd2, 32'h0040_0000);
    rd(3'd3, d); chk("R8 tx reset", d, 32'h0050_0000);

    // R12 transmit interrupt
    wr(3'd2, 32'h1000_0000);
    chk("R12 irq_tx", {31'd0, irq_tx}, 32'd1);
    wr(3'd2, 32'h0);
    chk("R12 irq_tx off", {31'd0, irq_tx}, 32'd0);

    // R3 R4 R5 looped-back frame table
    loop = 1'b1;
    for (int v = 0; v < 6; v++) begin
      cfg = 32'h0000_B001 | (32'(VEC[v][16]) << 16) | (32'(VEC[v][17]) << 18)
          | (32'(VEC[v][18]) << 19) | (32'(VEC[v][20:19]) << 20);
      wr(3'd2, cfg);
      wr(3'd0, {24'd0, VEC[v][15:8]});
      idle(160);
      rd(3'd3, d); chk("R3 R4 R5 loop status", d, 32'h0040_0001);
      rd(3'd1, d); chk("R3 loop data", d, {24'd0, VEC[v][7:0]});
    end

    // R2 bit time with divisor 2: start bit low for 12 clocks
    wr(3'd2, 32'h0000_B002);
    wr(3'd0, 32'h01);
    while (ser_txd) @(negedge clk);
    w = 0;
    while (!ser_txd && w < 100) begin @(negedge clk); w++; end
    chk("R2 bit time", 32'(w), 32'd12);
    idle(200);
    rd(3'd1, d); chk("R2 char back", d, 32'h01);

    // R13 busy flags mid-frame
    wr(3'd2, 32'h0000_B001);
    wr(3'd0, 32'h5A);
    idle(30);
    rd(3'd3, d); chk("R13 busy", d & 32'h0600_0000, 32'h0600_0000);
    idle(150);
    rd(3'd1, d); chk("R13 char", d, 32'h5A);

    // R11 flow control gating and rts inversion
    wr(3'd2, 32'h8000_1001);
    chk("R11 rts inverted", {31'd0, rts_out}, 32'd0);
    cts_in = 1'b0;
    wr(3'd0, 32'h55);
    idle(100);
    rd(3'd3, d); chk("R11 held", (d >> 8) & 32'h7F, 32'd1);
    chk("R11 txd idle", {31'd0, ser_txd}, 32'd1);
    cts_in = 1'b1;
    idle(150);
    rd(3'd3, d); chk("R11 released", (d >> 8) & 32'h7F, 32'd0);

    // R4 parity error: even parity, char 03, wrong parity bit 1
    loop = 1'b0;
    wr(3'd2, 32'h0808_A001 | 32'h0080_0000);
    drive({1'b1, 1'b1, 1'b1, 8'h03, 1'b0}, 12);
    idle(20);
    rd(3'd3, d); chk("R4 parity flag", d, 32'h0041_0001);
    chk("R12 irq_rx", {31'd0, irq_rx}, 32'd1);
    rd(3'd1, d); chk("R4 char kept", d, 32'h03);
    chk("R12 irq_rx by error", {31'd0, irq_rx}, 32'd1);
    wr(3'd2, 32'h4808_A001);
    chk("R12 irq_rx masked", {31'd0, irq_rx}, 32'd0);

    // R5 framing error: char 55, stop bit low
    wr(3'd2, 32'h0900_A001);
    drive({2'b11, 1'b0, 8'h55, 1'b0}, 12);
    idle(20);
    rd(3'd3, d); chk("R5 frame flag", d, 32'h0042_0001);
    rd(3'd1, d); chk("R5 char kept", d, 32'h55);

    // R8 receive reset empties queue
    drive({2'b11, 1'b1, 8'h77, 1'b0}, 12);
    idle(20);
    wr(3'd2, 32'h0180_A001);
    rd(3'd3, d); chk("R8 rx reset", d, 32'h0050_0000);

    // R9 both lines inverted, looped back
    loop = 1'b1;
    wr(3'd2, 32'h0600_B001);
    chk("R9 txd idle low", {31'd0, ser_txd}, 32'd0);
    idle(20);
    wr(3'd0, 32'h96);
    idle(160);
    rd(3'd1, d); chk("R9 inverted loop", d, 32'h96);

    finish_run();
  end
endmodule